// File: doc/BRIEF.md
# LDPC Circular-Buffer Rate Matcher

This block turns one LDPC codeword into the exact number of transmitted bits a code block needs. The codeword is first loaded, 32 bits per write, into a local bit buffer. Position 0 of that buffer holds the first codeword bit after the 2·Zc systematic bits that are always punctured. For each code block a start pulse captures the parameters: base graph, lifting size Zc, filler (null) count, modulation order select, output length E, start offset k0 and circular limit Ncb. The block then walks the buffer circularly from k0, skips the filler bits, and wraps around the effective circulating length as often as E requires. It applies a row/column bit interleaver over Qm rows and streams the result as 32-bit words with start and end markers. The output is held while the consumer is not ready.

A controlling state machine sequences each block. From `ST_IDLE`, a `cfg_start` pulse goes to `ST_COLS`, where a shared serial divider computes the column count C = E/Qm. On divider completion the machine goes to `ST_WRAP`, which reuses the divider to reduce C modulo the circulating length L. On the next completion it goes to `ST_ROWS`, which sets one read pointer per interleaver row over Qm cycles. After the last row it goes to `ST_STREAM`, which emits one bit per accepted cycle. When the final bit is taken it returns to `ST_IDLE`.

Top module: `cbuf_rate_matcher`

## Requirements
- R1: After reset `out_valid`, `out_sop` and `out_eop` are low and `cfg_ready` is high.
- R2: A block yields exactly ceil(E/32) output words. `out_sop` is set on the first word only and `out_eop` on the last word only. Bits of the last word at or above E mod 32 (when that is non-zero) are zero. No word follows the end word until a new start.
- R3: Output bit 0 of each word is the earliest bit of that word; bit i is the i-th in time.
- R4: The buffer is loaded with `buf_we`: word w bit b is codeword position 32·w+b. Bits are read from position k0 upward and wrap to 0 at min(Ncb, N). N is 66·Zc when `cfg_bg`=0 and 50·Zc when `cfg_bg`=1. Reading continues around the circle for as long as E needs, including E larger than the circulating length.
- R5: With K = 22·Zc (`cfg_bg`=0) or 10·Zc (`cfg_bg`=1), positions K−F−2·Zc up to K−2·Zc−1 (F = `cfg_nulls`) are never emitted, and their contents have no effect on the output.
- R6: The circulating length L is set from Ncb and the null region as follows:
  - Ncb itself when Ncb is below K−F−2Zc.
  - K−F−2Zc when Ncb lies between that and K−2Zc.
  - Ncb−F when Ncb lies between K−2Zc and N.
  - N−F when Ncb is N or above.
- R7: `cfg_qm_sel` 0,1,2,3,4 selects Qm = 1,2,4,6,8. With e the selected sequence and C = E/Qm, output bit j = c·Qm + r carries e[r·C + c].
- R8: While `out_valid` is high and `out_ready` low, `out_data`, `out_sop`, `out_eop` and `out_valid` hold; no bit is lost or repeated under any ready pattern.
- R9: `cfg_start` is ignored while `cfg_ready` is low; the running block's output is unchanged.
- R10: Blocks may follow one another with no gap; each has its own start and end word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| buf_we | input | 1 | Buffer word write enable |
| buf_waddr | input | $clog2(BUF_WORDS) | Buffer word address |
| buf_wdata | input | 32 | Buffer word, bit b = position 32·addr+b |
| cfg_start | input | 1 | Start a block with the cfg_* values (taken only when idle) |
| cfg_bg | input | 1 | Base graph: 0 large, 1 small |
| cfg_zc | input | 9 | Lifting size Zc |
| cfg_nulls | input | 10 | Filler bit count F |
| cfg_qm_sel | input | 3 | Modulation order select (0..4) |
| cfg_e | input | 21 | Output length E in bits |
| cfg_k0 | input | 15 | Start offset k0 |
| cfg_ncb | input | 15 | Circular buffer limit Ncb |
| cfg_ready | output | 1 | High when a new block may start |
| out_ready | input | 1 | Consumer accepts the current word |
| out_data | output | 32 | Output word |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | First word of a block |
| out_eop | output | 1 | Last word of a block |

## Verification
The bench targets the following cases:
- An E larger than L, so the read wraps several times. A design that wraps at Ncb instead of L would repeat the wrong bits or reach into the null region.
- Ncb values in each of the four ranges of the circulating-length rule. A wrong range choice shifts every bit after the first wrap.
- Each Qm from 1 to 8, including 6, which is not a power of two. Row pointers seeded from a wrong C mod L would scramble whole rows.
- An E that fills its last word exactly. Off-by-one word counts would show up as a missing or extra end marker.
- A stalling consumer, a start pulse during a running block, and filler contents changed between runs. A design that lets any of these leak through would corrupt data or markers.

// File: rtl/rm_pkg.sv
package rm_pkg;
    localparam int WORD_W = 32;
    localparam int E_W    = 21;
    localparam int POS_W  = 15;
    localparam int ZC_W   = 9;
    localparam int NULL_W = 10;
    localparam int QSEL_W = 3;
    localparam int MAX_QM = 8;
    localparam int LEN_W  = POS_W + 1;
    localparam int ROW_W  = $clog2(MAX_QM);
    localparam int QM_W   = $clog2(MAX_QM + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLS,
        ST_WRAP,
        ST_ROWS,
        ST_STREAM
    } rm_state_e;

    typedef struct packed {
        logic              bg;
        logic [ZC_W-1:0]   zc;
        logic [NULL_W-1:0] nulls;
        logic [QSEL_W-1:0] qsel;
        logic [E_W-1:0]    e;
        logic [POS_W-1:0]  k0;
        logic [POS_W-1:0]  ncb;
    } rm_cfg_t;

    function automatic logic [QM_W-1:0] qm_of(input logic [QSEL_W-1:0] sel);
        logic [QM_W-1:0] q;
        case (sel)
            3'd0:    q = QM_W'(1);
            3'd1:    q = QM_W'(2);
            3'd2:    q = QM_W'(4);
            3'd3:    q = QM_W'(6);
            default: q = QM_W'(8);
        endcase
        return q;
    endfunction
endpackage

// File: rtl/rm_geometry.sv
module rm_geometry
    import rm_pkg::*;
(
    input  rm_cfg_t          cfg,
    output logic [LEN_W-1:0] sys_end,
    output logic [LEN_W-1:0] null_end,
    output logic [LEN_W-1:0] nulls,
    output logic [LEN_W-1:0] eff_len
);
    logic [LEN_W-1:0] zc;
    logic [LEN_W-1:0] two_z;
    logic [LEN_W-1:0] k_len;
    logic [LEN_W-1:0] cw_len;
    logic [LEN_W-1:0] ncb_ext;
    logic [LEN_W-1:0] ncb_c;

    always_comb begin
        zc       = LEN_W'(cfg.zc);
        two_z    = zc << 1;
        k_len    = cfg.bg ? LEN_W'(10) * zc : LEN_W'(22) * zc;
        cw_len   = cfg.bg ? LEN_W'(50) * zc : LEN_W'(66) * zc;
        nulls    = LEN_W'(cfg.nulls);
        null_end = k_len - two_z;
        sys_end  = null_end - nulls;
        ncb_ext  = LEN_W'(cfg.ncb);
        ncb_c    = (ncb_ext < cw_len) ? ncb_ext : cw_len;
        if (ncb_c <= sys_end) begin
            eff_len = ncb_c;
        end else if (ncb_c < null_end) begin
            eff_len = sys_end;
        end else begin
            eff_len = ncb_c - nulls;
        end
    end
endmodule

// File: rtl/rm_divider.sv
module rm_divider #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [W:0]       shifted;
    logic             fits;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        fits    = shifted >= {1'b0, den};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                rem_q  <= '0;
                quo_q  <= num;
                cnt_q  <= CNT_W'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= fits ? W'(shifted - {1'b0, den}) : W'(shifted);
                quo_q  <= {quo_q[W-2:0], fits};
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quo  = quo_q;
    assign rem  = rem_q;

    p_done_follows_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(busy_q));
endmodule

// File: rtl/rm_word_packer.sv
module rm_word_packer #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              bit_last,
    output logic              accept,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop
);
    localparam int IDX_W = $clog2(WORD_W);

    logic [WORD_W-1:0] acc_q;
    logic [IDX_W-1:0]  cnt_q;
    logic              first_q;
    logic              slot_free;
    logic              completes;
    logic              take;
    logic [WORD_W-1:0] word_nx;

    always_comb begin
        slot_free        = !out_valid || out_ready;
        completes        = (cnt_q == IDX_W'(WORD_W - 1)) || bit_last;
        accept           = !completes || slot_free;
        take             = bit_vld && accept;
        word_nx          = acc_q;
        word_nx[cnt_q]   = bit_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            first_q   <= 1'b1;
            out_data  <= '0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else begin
            if (take && completes) begin
                out_data  <= word_nx;
                out_valid <= 1'b1;
                out_sop   <= first_q;
                out_eop   <= bit_last;
                acc_q     <= '0;
                cnt_q     <= '0;
                first_q   <= bit_last;
            end else begin
                if (take) begin
                    acc_q <= word_nx;
                    cnt_q <= cnt_q + 1'b1;
                end
                if (out_valid && out_ready) begin
                    out_valid <= 1'b0;
                    out_sop   <= 1'b0;
                    out_eop   <= 1'b0;
                end
            end
        end
    end

    p_hold_stalled_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sop) && $stable(out_eop)));
    p_markers_with_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);
endmodule

// File: rtl/cbuf_rate_matcher.sv
module cbuf_rate_matcher
    import rm_pkg::*;
#(
    parameter int BUF_WORDS = 256,
    localparam int AW = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [AW-1:0]     buf_waddr,
    input  logic [31:0]       buf_wdata,
    input  logic              cfg_start,
    input  logic              cfg_bg,
    input  logic [8:0]        cfg_zc,
    input  logic [9:0]        cfg_nulls,
    input  logic [2:0]        cfg_qm_sel,
    input  logic [20:0]       cfg_e,
    input  logic [14:0]       cfg_k0,
    input  logic [14:0]       cfg_ncb,
    output logic              cfg_ready,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop
);
    rm_state_e state_q, state_d;

    logic [WORD_W-1:0] mem [BUF_WORDS];
    rm_cfg_t           cfg_q;
    logic [QM_W-1:0]   qm_q;
    logic [E_W-1:0]    cols_q;
    logic [LEN_W-1:0]  colmod_q;
    logic [LEN_W-1:0]  walk_q;
    logic [ROW_W-1:0]  row_i_q;
    logic [ROW_W-1:0]  row_sel_q;
    logic [E_W-1:0]    bits_left_q;
    logic [LEN_W-1:0]  ptr_q [MAX_QM];
    logic              div_go_q;

    logic [LEN_W-1:0]  sys_end, null_end, nulls_ext, eff_len;
    logic [E_W-1:0]    div_num, div_den, div_quo, div_rem;
    logic              div_done;
    logic              accept, step, last_bit, rd_bit;
    logic [LEN_W-1:0]  k0_ext, k0n, cur_ptr, nxt_ptr, bit_pos, walk_sum;
    logic [AW-1:0]     rd_word;
    logic [WORD_W-1:0] rd_data;
    logic              row_wrap_rows, row_wrap_strm;

    // Buffer load port
    always_ff @(posedge clk) begin
        if (buf_we) begin
            mem[buf_waddr] <= buf_wdata;
        end
    end

    rm_geometry u_geom (
        .cfg      (cfg_q),
        .sys_end  (sys_end),
        .null_end (null_end),
        .nulls    (nulls_ext),
        .eff_len  (eff_len)
    );

    always_comb begin
        div_num = (state_q == ST_COLS) ? cfg_q.e : cols_q;
        div_den = (state_q == ST_COLS) ? E_W'(qm_q) : E_W'(eff_len);
    end

    rm_divider #(.W(E_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go_q),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo),
        .rem   (div_rem)
    );

    // Bit fetch from the non-null index of the current row
    always_comb begin
        k0_ext        = LEN_W'(cfg_q.k0);
        k0n           = (k0_ext >= null_end) ? k0_ext - nulls_ext : k0_ext;
        cur_ptr       = ptr_q[row_sel_q];
        nxt_ptr       = cur_ptr + 1'b1;
        bit_pos       = (cur_ptr < sys_end) ? cur_ptr : cur_ptr + nulls_ext;
        rd_word       = AW'(bit_pos >> 5);
        rd_data       = mem[rd_word];
        rd_bit        = rd_data[bit_pos[4:0]];
        walk_sum      = walk_q + colmod_q;
        row_wrap_rows = ({1'b0, row_i_q} == qm_q - 1'b1);
        row_wrap_strm = ({1'b0, row_sel_q} == qm_q - 1'b1);
        last_bit      = (bits_left_q == E_W'(1));
        step          = (state_q == ST_STREAM) && accept;
    end

    rm_word_packer #(.WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (state_q == ST_STREAM),
        .bit_val   (rd_bit),
        .bit_last  (last_bit),
        .accept    (accept),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cfg_start) state_d = ST_COLS;
            ST_COLS:   if (div_done) state_d = ST_WRAP;
            ST_WRAP:   if (div_done) state_d = ST_ROWS;
            ST_ROWS:   if (row_wrap_rows) state_d = ST_STREAM;
            ST_STREAM: if (step && last_bit) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers driven by state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            qm_q        <= '0;
            cols_q      <= '0;
            colmod_q    <= '0;
            walk_q      <= '0;
            row_i_q     <= '0;
            row_sel_q   <= '0;
            bits_left_q <= '0;
            div_go_q    <= 1'b0;
            for (int i = 0; i < MAX_QM; i++) begin
                ptr_q[i] <= '0;
            end
        end else begin
            div_go_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cfg_start) begin
                        cfg_q    <= '{bg: cfg_bg, zc: cfg_zc, nulls: cfg_nulls,
                                      qsel: cfg_qm_sel, e: cfg_e, k0: cfg_k0,
                                      ncb: cfg_ncb};
                        qm_q     <= qm_of(cfg_qm_sel);
                        div_go_q <= 1'b1;
                    end
                end
                ST_COLS: begin
                    if (div_done) begin
                        cols_q   <= div_quo;
                        div_go_q <= 1'b1;
                    end
                end
                ST_WRAP: begin
                    if (div_done) begin
                        colmod_q <= LEN_W'(div_rem);
                        walk_q   <= (k0n >= eff_len) ? k0n - eff_len : k0n;
                        row_i_q  <= '0;
                    end
                end
                ST_ROWS: begin
                    ptr_q[row_i_q] <= walk_q;
                    walk_q  <= (walk_sum >= eff_len) ? walk_sum - eff_len : walk_sum;
                    row_i_q <= row_i_q + 1'b1;
                    if (row_wrap_rows) begin
                        row_sel_q   <= '0;
                        bits_left_q <= cfg_q.e;
                    end
                end
                ST_STREAM: begin
                    if (step) begin
                        ptr_q[row_sel_q] <= (nxt_ptr == eff_len) ? '0 : nxt_ptr;
                        row_sel_q   <= row_wrap_strm ? '0 : row_sel_q + 1'b1;
                        bits_left_q <= bits_left_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cfg_ready = (state_q == ST_IDLE);

    for (genvar g = 0; g < MAX_QM; g++) begin : g_rowchk
        p_row_ptr_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_STREAM && QM_W'(g) < qm_q) |-> (ptr_q[g] < eff_len));
    end

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(cfg_q));

    p_eff_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM) |-> (eff_len > LEN_W'(32) && eff_len <= LEN_W'(cfg_q.ncb)));
endmodule

// File: tb/cbuf_rate_matcher_tb.sv
module cbuf_rate_matcher_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BUF_WORDS  = 256;
    localparam int BUF_BITS   = BUF_WORDS * 32;
    localparam int MAX_E      = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        buf_we = 1'b0;
    logic [7:0]  buf_waddr = '0;
    logic [31:0] buf_wdata = '0;
    logic        cfg_start = 1'b0;
    logic        cfg_bg = 1'b0;
    logic [8:0]  cfg_zc = '0;
    logic [9:0]  cfg_nulls = '0;
    logic [2:0]  cfg_qm_sel = '0;
    logic [20:0] cfg_e = '0;
    logic [14:0] cfg_k0 = '0;
    logic [14:0] cfg_ncb = '0;
    logic        cfg_ready;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_valid, out_sop, out_eop;

    bit cw    [BUF_BITS];
    bit ebits [MAX_E];
    bit obits [MAX_E];
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cbuf_rate_matcher #(.BUF_WORDS(BUF_WORDS)) dut_i (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .cfg_start(cfg_start), .cfg_bg(cfg_bg),
        .cfg_zc(cfg_zc), .cfg_nulls(cfg_nulls), .cfg_qm_sel(cfg_qm_sel),
        .cfg_e(cfg_e), .cfg_k0(cfg_k0), .cfg_ncb(cfg_ncb), .cfg_ready(cfg_ready),
        .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Fill the bench copy with pseudo-random bits, optionally inverting the
    // null region [lo,hi), then load it into the design.
    task automatic load_buffer(input int seed, input int lo, input int hi, input bit inv);
        int s = seed;
        for (int i = 0; i < BUF_BITS; i++) begin
            s = s * 1103515245 + 12345;
            cw[i] = s[16];
            if (inv && i >= lo && i < hi) cw[i] = ~s[16];
        end
        for (int w = 0; w < BUF_WORDS; w++) begin
            @(negedge clk);
            buf_we    = 1'b1;
            buf_waddr = 8'(w);
            for (int b = 0; b < 32; b++) buf_wdata[b] = cw[w * 32 + b];
        end
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    // Reference: walk positions from k0, wrap at min(Ncb,N), skip nulls,
    // then read the Qm x C matrix column by column.
    task automatic build_expected(input bit bg, input int zc, input int f, input int qsel,
                                  input int e, input int k0, input int ncb);
        int n_full = bg ? 50 * zc : 66 * zc;
        int k_len  = bg ? 10 * zc : 22 * zc;
        int hi     = k_len - 2 * zc;
        int lo     = hi - f;
        int lim    = (ncb < n_full) ? ncb : n_full;
        int qm     = (qsel == 0) ? 1 : (qsel == 1) ? 2 : (qsel == 2) ? 4 : (qsel == 3) ? 6 : 8;
        int cols   = e / qm;
        int p      = k0;
        int k      = 0;
        while (k < e) begin
            if (!(p >= lo && p < hi)) begin
                ebits[k] = cw[p];
                k++;
            end
            p++;
            if (p == lim) p = 0;
        end
        for (int j = 0; j < e; j++) obits[j] = ebits[(j % qm) * cols + (j / qm)];
    endtask

    task automatic run_case(input string req, input bit bg, input int zc, input int f,
                            input int qsel, input int e, input int k0, input int ncb,
                            input bit stall, input bit poke);
        int nwords = (e + 31) / 32;
        int got = 0;
        int cyc = 0;
        bit poked = 1'b0;
        logic [31:0] expw;
        build_expected(bg, zc, f, qsel, e, k0, ncb);
        @(negedge clk);
        while (!cfg_ready) @(negedge clk);
        cfg_bg = bg; cfg_zc = 9'(zc); cfg_nulls = 10'(f); cfg_qm_sel = 3'(qsel);
        cfg_e = 21'(e); cfg_k0 = 15'(k0); cfg_ncb = 15'(ncb);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        while (got < nwords && cyc < 20000) begin
            out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            if (poke && got == 1 && !poked) begin
                cfg_start = 1'b1; cfg_e = 21'd64; cfg_qm_sel = 3'd0; cfg_k0 = 15'd0;
                poked = 1'b1;
            end else begin
                cfg_start = 1'b0;
            end
            if (out_valid && out_ready) begin
                expw = '0;
                for (int b = 0; b < 32; b++)
                    if (got * 32 + b < e) expw[b] = obits[got * 32 + b];
                check(out_data === expw, req, $sformatf("R3 word %0d data", got), out_data, expw);
                check({out_sop, out_eop} === {got == 0, got == nwords - 1}, "R2",
                      $sformatf("%s word %0d markers", req, got),
                      {30'd0, out_sop, out_eop}, {30'd0, got == 0, got == nwords - 1});
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        cfg_start = 1'b0;
        out_ready = 1'b1;
        check(got == nwords, "R2", $sformatf("%s word count", req), 32'(got), 32'(nwords));
        check(out_valid == 1'b0, "R2", $sformatf("%s no word after end", req),
              {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_reset();
        check({out_valid, out_sop, out_eop, cfg_ready} === 4'b0001, "R1", "reset outputs",
              {28'd0, out_valid, out_sop, out_eop, cfg_ready}, 32'd1);
    endtask

    task automatic t_bpsk_full_circle();   // R4 R7: Qm=1, Ncb >= N, L = N-F
        run_case("R4", 1'b1, 8, 16, 0, 100, 0, 400, 1'b0, 1'b0);
    endtask

    task automatic t_qpsk_wrap();          // R4 R6: E > L, Ncb in [K-2Zc, N)
        run_case("R4", 1'b1, 8, 16, 1, 600, 96, 200, 1'b0, 1'b0);
    endtask

    task automatic t_16qam_mid_range();    // R6: Ncb in [K'-2Zc, K-2Zc)
        run_case("R6", 1'b1, 8, 16, 2, 200, 8, 56, 1'b0, 1'b0);
    endtask

    task automatic t_64qam_short_ncb();    // R6 R7: Ncb < K'-2Zc, Qm=6
        run_case("R7", 1'b1, 8, 16, 3, 126, 16, 40, 1'b0, 1'b0);
    endtask

    task automatic t_256qam_bg1_exact();   // R2 R7: E multiple of 32, base graph 0
        run_case("R7", 1'b0, 4, 8, 4, 512, 80, 264, 1'b0, 1'b0);
    endtask

    task automatic t_backpressure();       // R8
        run_case("R8", 1'b1, 8, 16, 1, 600, 96, 200, 1'b1, 1'b0);
    endtask

    task automatic t_start_ignored();      // R9
        run_case("R9", 1'b1, 8, 16, 2, 400, 24, 60, 1'b1, 1'b1);
    endtask

    task automatic t_back_to_back();       // R10
        run_case("R10", 1'b1, 8, 16, 0, 100, 0, 400, 1'b0, 1'b0);
        run_case("R10", 1'b1, 8, 16, 3, 126, 16, 40, 1'b0, 1'b0);
    endtask

    task automatic t_null_content();       // R5: null region 48..63 for Zc=8, F=16
        load_buffer(77, 48, 64, 1'b1);
        run_case("R5", 1'b1, 8, 16, 1, 600, 0, 400, 1'b0, 1'b0);
        load_buffer(77, 48, 64, 1'b0);
        run_case("R5", 1'b1, 8, 16, 1, 600, 0, 400, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        load_buffer(12345, 0, 0, 1'b0);
        t_bpsk_full_circle();
        t_qpsk_wrap();
        t_16qam_mid_range();
        t_64qam_short_ncb();
        t_256qam_bg1_exact();
        t_backpressure();
        t_start_ignored();
        t_back_to_back();
        t_null_content();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule